// File: doc/BRIEF.md
# Banked Two-Write Two-Read RAM

This block is a memory that completes two writes and two reads on every rising clock edge. It is built only from simple storage arrays that each have one write address and one read address. The address range is cut into equal sectors, and each sector is held in its own bank. Steering logic sends each write to the bank its address falls in. Every bank is kept as two identical copies. Both copies take the same write, and each copy serves one of the two read ports. As a result the two reads never compete for an array port.

Full write throughput holds only while the two writes of a cycle land in different sectors. When both writes target the same sector, write port 1 is stored and write port 0 is dropped. A sticky flag then records the event so that surrounding logic can tell that a write was lost. Reads are registered, with a latency of one cycle. A read of a word that is written on the same edge returns the contents from before that write.

Top module: `ramb_2w2r`

## Requirements
- R1: When `wr_en` is high and the two write addresses lie in different sectors, both words are stored on that edge. A later read of either address returns the word that was written to it.
- R2: When `rd_en` is high, `rd0_data` and `rd1_data` show the words at `rd0_addr` and `rd1_addr` one cycle later. This holds for any pair of read addresses, including the same address or the same sector on both ports.
- R3: When `wr_en` is low, no word is changed, whatever the write addresses and data are.
- R4: When `rd_en` is low, `rd0_data` and `rd1_data` keep their previous values.
- R5: The sector of an address is given by its top log2(NSEC) bits. With the default of 4 sectors, bits [AW-1:AW-2] choose the sector. Addresses that differ only in those bits do not collide. Addresses that share them do collide.
- R6: When `wr_en` is high and both write addresses lie in the same sector, only write port 1 is stored. Write port 0 changes nothing.
- R7: The cycle after a same-sector write pair, `collide` goes high. It stays high until reset and goes high for no other reason.
- R8: A read of an address that is written on the same edge returns the old word. The new word is returned from the following cycle on.
- R9: After reset, `collide`, `rd0_data` and `rd1_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the read registers and the flag |
| wr_en | input | 1 | Write enable shared by both write ports |
| wr0_addr | input | AW | Write port 0 address |
| wr0_data | input | DW | Write port 0 data |
| wr1_addr | input | AW | Write port 1 address |
| wr1_data | input | DW | Write port 1 data |
| rd_en | input | 1 | Read enable shared by both read ports |
| rd0_addr | input | AW | Read port 0 address |
| rd1_addr | input | AW | Read port 1 address |
| rd0_data | output | DW | Read port 0 data, one cycle after the address |
| rd1_data | output | DW | Read port 1 data, one cycle after the address |
| collide | output | 1 | Sticky flag: a same-sector write pair has occurred |

## Verification
Two kinds of events can land on the same edge. A write and a read can hit one address, and two writes can hit one sector. The bench provokes the first case by reading the address it writes in the same cycle. It expects the old word, and the new word from the next cycle on. It provokes the second case with pairs that share the top address bits, including a pair with the identical address. Here it expects only the port 1 word to be stored and the flag to rise one cycle later. A behavioural array model judges every cycle, and it runs between the directed cases under random traffic that never collides.

// File: rtl/ramb_pkg.sv
package ramb_pkg;

    // Which write port owns a bank in the current cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_P0   = 2'd1,
        SRC_P1   = 2'd2
    } wsrc_e;

    // Port 1 has priority when both ports hit the same bank.
    function automatic wsrc_e pick_src(input logic en, input logic hit0, input logic hit1);
        if (!en)
            return SRC_NONE;
        else if (hit1)
            return SRC_P1;
        else if (hit0)
            return SRC_P0;
        else
            return SRC_NONE;
    endfunction

endpackage

// File: rtl/ramb_array.sv
// Simple dual-port storage: one write port, one registered read port.
// A read sees the contents from before a write on the same edge.
module ramb_array #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_st_t;

    logic [DW-1:0] mem [DEPTH];
    rd_st_t        st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (re)
            st_d.rdata = mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/ramb_wsteer.sv
// Picks which write port, if any, writes the bank BANK_ID this cycle.
module ramb_wsteer #(
    parameter int DW      = 16,
    parameter int AW      = 8,
    parameter int SB      = 2,
    parameter int BANK_ID = 0
) (
    input  logic           wr_en,
    input  logic [AW-1:0]  wr0_addr,
    input  logic [DW-1:0]  wr0_data,
    input  logic [AW-1:0]  wr1_addr,
    input  logic [DW-1:0]  wr1_data,
    output logic           we,
    output logic [AW-SB-1:0] waddr,
    output logic [DW-1:0]  wdata
);
    import ramb_pkg::*;

    localparam int BAW = AW - SB;
    localparam logic [SB-1:0] ID = SB'(BANK_ID);

    logic  hit0, hit1;
    wsrc_e src;

    assign hit0 = (wr0_addr[AW-1 -: SB] == ID);
    assign hit1 = (wr1_addr[AW-1 -: SB] == ID);

    always_comb begin
        src   = pick_src(wr_en, hit0, hit1);
        we    = 1'b0;
        waddr = '0;
        wdata = '0;
        case (src)
            SRC_P0: begin
                we    = 1'b1;
                waddr = wr0_addr[BAW-1:0];
                wdata = wr0_data;
            end
            SRC_P1: begin
                we    = 1'b1;
                waddr = wr1_addr[BAW-1:0];
                wdata = wr1_data;
            end
            default: begin
                we    = 1'b0;
                waddr = '0;
                wdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/ramb_bank.sv
// One sector: write steering plus NRD copies, one per read port.
module ramb_bank #(
    parameter int DW      = 16,
    parameter int AW      = 8,
    parameter int SB      = 2,
    parameter int NRD     = 2,
    parameter int BANK_ID = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr0_addr,
    input  logic [DW-1:0]                 wr0_data,
    input  logic [AW-1:0]                 wr1_addr,
    input  logic [DW-1:0]                 wr1_data,
    input  logic                          rd_en,
    input  logic [NRD-1:0][AW-SB-1:0]     rd_addr,
    output logic                          bank_we,
    output logic [NRD-1:0][DW-1:0]        rd_data
);
    localparam int BAW = AW - SB;

    logic           we;
    logic [BAW-1:0] waddr;
    logic [DW-1:0]  wdata;

    ramb_wsteer #(
        .DW(DW), .AW(AW), .SB(SB), .BANK_ID(BANK_ID)
    ) u_steer (
        .wr_en    (wr_en),
        .wr0_addr (wr0_addr),
        .wr0_data (wr0_data),
        .wr1_addr (wr1_addr),
        .wr1_data (wr1_data),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata)
    );

    assign bank_we = we;

    for (genvar r = 0; r < NRD; r++) begin : g_rep
        ramb_array #(.DW(DW), .AW(BAW)) u_arr (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .re    (rd_en),
            .raddr (rd_addr[r]),
            .rdata (rd_data[r])
        );
    end

endmodule

// File: rtl/ramb_2w2r.sv
// Two writes and two reads per clock, built from sector banks of
// simple dual-port arrays, each bank duplicated for the read ports.
module ramb_2w2r #(
    parameter int DW   = 16,
    parameter int AW   = 8,
    parameter int NSEC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr0_addr,
    input  logic [DW-1:0] wr0_data,
    input  logic [AW-1:0] wr1_addr,
    input  logic [DW-1:0] wr1_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd0_addr,
    input  logic [AW-1:0] rd1_addr,
    output logic [DW-1:0] rd0_data,
    output logic [DW-1:0] rd1_data,
    output logic          collide
);
    localparam int SB  = $clog2(NSEC);
    localparam int BAW = AW - SB;
    localparam int NRD = 2;

    typedef struct packed {
        logic [SB-1:0] sel0;
        logic [SB-1:0] sel1;
        logic          collide;
    } top_st_t;

    logic [SB-1:0]                     wsec0, wsec1;
    logic [NSEC-1:0]                   bank_we;
    logic [NSEC-1:0][NRD-1:0][DW-1:0]  bank_rd;
    logic [NRD-1:0][BAW-1:0]           rd_low;
    top_st_t                           st_d, st_q;

    assign wsec0     = wr0_addr[AW-1 -: SB];
    assign wsec1     = wr1_addr[AW-1 -: SB];
    assign rd_low[0] = rd0_addr[BAW-1:0];
    assign rd_low[1] = rd1_addr[BAW-1:0];

    for (genvar b = 0; b < NSEC; b++) begin : g_bank
        ramb_bank #(
            .DW(DW), .AW(AW), .SB(SB), .NRD(NRD), .BANK_ID(b)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr0_addr (wr0_addr),
            .wr0_data (wr0_data),
            .wr1_addr (wr1_addr),
            .wr1_data (wr1_data),
            .rd_en    (rd_en),
            .rd_addr  (rd_low),
            .bank_we  (bank_we[b]),
            .rd_data  (bank_rd[b])
        );
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.sel0 = rd0_addr[AW-1 -: SB];
            st_d.sel1 = rd1_addr[AW-1 -: SB];
        end
        if (wr_en && (wsec0 == wsec1))
            st_d.collide = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd0_data = bank_rd[st_q.sel0][0];
    assign rd1_data = bank_rd[st_q.sel1][1];
    assign collide  = st_q.collide;

endmodule

// File: rtl/ramb_chk.sv
module ramb_chk #(
    parameter int DW   = 16,
    parameter int AW   = 8,
    parameter int NSEC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr0_addr,
    input logic [AW-1:0]   wr1_addr,
    input logic            rd_en,
    input logic [DW-1:0]   rd0_data,
    input logic [DW-1:0]   rd1_data,
    input logic            collide,
    input logic [NSEC-1:0] bank_we
);
    localparam int SB = $clog2(NSEC);

    logic [SB-1:0] s0, s1;
    logic          same;

    assign s0   = wr0_addr[AW-1 -: SB];
    assign s1   = wr1_addr[AW-1 -: SB];
    assign same = (s0 == s1);

    assert_two_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !same) |-> ($countones(bank_we) == 2));

    assert_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (bank_we == '0));

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd0_data) && $stable(rd1_data)));

    assert_port1_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> bank_we[s1]);

    assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && same) |-> ($countones(bank_we) == 1));

    assert_collide_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && same) |=> collide);

    assert_collide_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> collide);

    assert_collide_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!collide && !(wr_en && same)) |=> !collide);

endmodule

bind ramb_2w2r ramb_chk #(.DW(DW), .AW(AW), .NSEC(NSEC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr0_addr (wr0_addr),
    .wr1_addr (wr1_addr),
    .rd_en    (rd_en),
    .rd0_data (rd0_data),
    .rd1_data (rd1_data),
    .collide  (collide),
    .bank_we  (bank_we)
);

// File: tb/ramb_2w2r_test.sv
module ramb_2w2r_test;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, rd_en;
    logic [AW-1:0] wr0_addr, wr1_addr, rd0_addr, rd1_addr;
    logic [DW-1:0] wr0_data, wr1_data;
    logic [DW-1:0] rd0_data, rd1_data;
    logic          collide;

    logic [DW-1:0] mdl [256];
    logic [DW-1:0] exp0, exp1;
    logic          expc;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 0;

    always #5 clk = ~clk;

    ramb_2w2r #(.DW(DW), .AW(AW), .NSEC(4)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .rd_en(rd_en), .rd0_addr(rd0_addr), .rd1_addr(rd1_addr),
        .rd0_data(rd0_data), .rd1_data(rd1_data), .collide(collide)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic compare(input string tag);
        check(rd0_data === exp0, tag, "rd0_data", int'(rd0_data), int'(exp0));
        check(rd1_data === exp1, tag, "rd1_data", int'(rd1_data), int'(exp1));
        check(collide === expc,  tag, "collide",  int'(collide),  int'(expc));
    endtask

    // Called at a falling edge; applies one cycle and compares after it.
    task automatic step(input string tag, input logic we,
                        input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                        input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                        input logic re, input logic [AW-1:0] r0,
                        input logic [AW-1:0] r1);
        wr_en = we; wr0_addr = a0; wr0_data = d0; wr1_addr = a1; wr1_data = d1;
        rd_en = re; rd0_addr = r0; rd1_addr = r1;
        if (re) begin
            exp0 = mdl[r0];
            exp1 = mdl[r1];
        end
        if (we) begin
            if (a0[7:6] == a1[7:6]) begin
                mdl[a1] = d1;
                expc = 1'b1;
            end else begin
                mdl[a0] = d0;
                mdl[a1] = d1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 0; rd_en = 0;
        wr0_addr = '0; wr1_addr = '0; rd0_addr = '0; rd1_addr = '0;
        wr0_data = '0; wr1_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp0 = '0; exp1 = '0; expc = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        compare("R9 reset state");

        // R1: fill every word with two writes per cycle, sectors differ in bit 7
        for (int i = 0; i < 128; i++)
            step("R1 fill", 1'b1, AW'(i), DW'(16'h1000 + i),
                 AW'(i + 128), DW'(16'h2000 + i), 1'b0, '0, '0);

        // R2: read back with random address pairs
        for (int i = 0; i < 300; i++)
            step("R2 readback", 1'b0, '0, '0, '0, '0, 1'b1,
                 AW'($urandom), AW'($urandom));
        // R2: both read ports on one address, then on one sector
        step("R2 same address", 1'b0, '0, '0, '0, '0, 1'b1, 8'h33, 8'h33);
        step("R2 same sector", 1'b0, '0, '0, '0, '0, 1'b1, 8'h40, 8'h7f);

        // R1/R2: random non-colliding traffic
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a0, a1;
            a0 = AW'($urandom);
            a1 = {a0[7:6] ^ 2'(1 + $urandom % 3), 6'($urandom)};
            step("R1 random", 1'($urandom % 4 != 0), a0, DW'($urandom), a1,
                 DW'($urandom), 1'($urandom % 5 != 0), AW'($urandom), AW'($urandom));
        end

        // R5: differ only in top bits -> both stored
        step("R5 split", 1'b1, 8'h05, 16'hAAAA, 8'h45, 16'hBBBB, 1'b0, '0, '0);
        step("R5 split read", 1'b0, '0, '0, '0, '0, 1'b1, 8'h05, 8'h45);

        // R3: write enable low leaves data unchanged
        step("R3 we low", 1'b0, 8'h10, 16'hDEAD, 8'h90, 16'hBEEF, 1'b0, '0, '0);
        step("R3 we low read", 1'b0, '0, '0, '0, '0, 1'b1, 8'h10, 8'h90);

        // R4: read enable low holds outputs
        step("R4 hold", 1'b0, '0, '0, '0, '0, 1'b0, 8'h05, 8'h10);
        step("R4 hold", 1'b1, 8'h11, 16'h1111, 8'hd1, 16'h2222, 1'b0, 8'h11, 8'hd1);

        // R8: same-cycle read returns old word, next cycle new word
        step("R8 old word", 1'b1, 8'h22, 16'h5A5A, 8'hE2, 16'hA5A5, 1'b1, 8'h22, 8'hE2);
        step("R8 new word", 1'b0, '0, '0, '0, '0, 1'b1, 8'h22, 8'hE2);

        // R5/R6/R7: same sector pair; port 1 wins, flag rises next cycle
        check(collide === 1'b0, "R7 pre", "collide", int'(collide), 0);
        step("R6 collide", 1'b1, 8'h20, 16'h0C0C, 8'h21, 16'h0D0D, 1'b0, '0, '0);
        step("R6 port1 only", 1'b0, '0, '0, '0, '0, 1'b1, 8'h20, 8'h21);
        step("R6 same addr", 1'b1, 8'h30, 16'h7777, 8'h30, 16'h8888, 1'b0, '0, '0);
        step("R6 same addr read", 1'b0, '0, '0, '0, '0, 1'b1, 8'h30, 8'h30);

        // R7: flag stays high through clean traffic, cleared only by reset
        for (int i = 0; i < 20; i++)
            step("R7 sticky", 1'b1, AW'(i), DW'(i), AW'(i + 128), DW'(i), 1'b1,
                 AW'(i), AW'(i + 64));
        do_reset();
        compare("R9 second reset");
        step("R7 clear after reset", 1'b1, 8'h01, 16'h0101, 8'hC1, 16'h0202,
             1'b1, 8'h01, 8'hC1);
        step("R7 clear after reset", 1'b0, '0, '0, '0, '0, 1'b1, 8'h01, 8'hC1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule